// File: doc/BRIEF.md
# PLL output clock gate controller

This block decides, cycle by cycle, whether the output clock of a phase-locked loop may pass its clock gate. Software sets an enable level. That level is carried into the output-clock side through a synchronizer, and an acknowledge returns through a second synchronizer. While the round trip is under way, a synchronization-busy flag is raised. The analog loop is represented by two stimulus inputs: an oscillator startup-complete flag and a raw lock indicator.

The first output edge is released under one of three startup policies, and the policy is chosen by a wake-up-fast bit and a 3-bit lock-time code:

- release at the end of oscillator startup;
- release on real lock;
- release after a fixed number of slow reference ticks.

Once the clock has been released, a bypass bit decides whether a later loss of lock stops the clock. A clock-ready status stays high from the first release until the block is disabled.

All logic runs on one clock. The synchronizer stages model the latency of the domain crossings.

Top module: `pllg_ctrl`

## Requirements
- R1: After reset, gate_en_o, clk_ready_o and sync_busy_o are all 0.
- R2: A change of enable_i sets sync_busy_o one cycle later. The flag stays high until the returned acknowledge matches the new enable value. With the default of two synchronizer stages, a rising enable gives 5 busy cycles. A falling enable while the clock is gated on gives 6 busy cycles, because the acknowledge falls only after the gate has closed.
- R3: Nothing is released while osc_ready_i is 0. Once osc_ready_i rises in the startup phase, the policy decision is made on the following cycle.
- R4: With wake_fast_i = 0 and lock_time_i = 0, the first release happens only on a cycle where lock_raw_i is 1.
- R5: With wake_fast_i = 0 and lock_time_i = c (c nonzero), a timer loads 2 << (c-1) at the end of startup. It decrements on each slow_tick_i pulse, and the first release follows the cycle in which it reads zero. lock_raw_i has no effect on this release.
- R6: With wake_fast_i = 1, the release follows startup directly, whatever lock_time_i and lock_raw_i are. If osc_ready_i is already high, gate_en_o rises 6 cycles after enable_i rises.
- R7: After release with lock_bypass_i = 0 and lock already seen, gate_en_o follows lock_raw_i one cycle later.
- R8: After a wake-fast release, loss of lock does not close the gate until lock_raw_i has been 1 at least once.
- R9: After release with lock_bypass_i = 1, gate_en_o stays 1 whatever lock_raw_i does.
- R10: clk_ready_o rises together with the first release and holds until the block is disabled. gate_en_o is never 1 while clk_ready_o is 0.
- R11: When enable_i falls, gate_en_o and clk_ready_o clear 4 cycles later and the lock timer is cleared. A later enable restarts the full startup sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Software enable level |
| osc_ready_i | input | 1 | Oscillator startup complete |
| lock_raw_i | input | 1 | Raw lock indicator from the loop |
| lock_time_i | input | 3 | Lock-time code; 0 selects real-lock release |
| wake_fast_i | input | 1 | Release at end of startup |
| lock_bypass_i | input | 1 | Ignore lock after release |
| slow_tick_i | input | 1 | Slow reference strobe for the lock timer |
| gate_en_o | output | 1 | Output clock gate enable |
| clk_ready_o | output | 1 | Output clock available |
| sync_busy_o | output | 1 | Enable synchronization in progress |

## Verification
The latencies are counted one register at a time:

| Event | Result | Due |
|---|---|---|
| Enable edge | sync_busy_o rises | 1 cycle later |
| Enable rise | the core sees the enable | 3 cycles later |
| Enable rise, osc_ready_i high, lock high or wake-fast | first release | 6 cycles after the edge |
| Disable | the gate closes | 4 cycles after the edge |
| Enable rise | busy clears | after 5 cycles |
| Disable of a running clock | busy clears | after 6 cycles |
| Lock change after release | gate follows | 1 cycle later |
| Final timer tick | release | 2 cycles after the tick |

The directed checks sample one cycle before and exactly at each of these points. Inputs are driven at falling edges and outputs are read at falling edges. The table-driven loop waits well beyond every latency before it compares, so the mode results are checked in their settled form.

// File: rtl/pllg_pkg.sv
package pllg_pkg;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_START = 2'd1,
      ST_ACQ   = 2'd2,
      ST_RUN   = 2'd3
   } pllg_state_t;

endpackage

// File: rtl/pllg_sync.sv
module pllg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("pllg_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] shreg;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= {shreg[STAGES-2:0], d};
      end
   end

   assign q = shreg[STAGES-1];

endmodule

// File: rtl/pllg_lock_timer.sv
module pllg_lock_timer #(
   parameter int LT_W     = 3,
   parameter int TMR_W    = 8,
   parameter int TMR_BASE = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            load,
   input  logic [LT_W-1:0] code,
   input  logic            tick,
   output logic            zero
);

   localparam int MAX_SHIFT = (1 << LT_W) - 2;

   if (TMR_BASE < 1) begin : g_bad_base
      $error("pllg_lock_timer: TMR_BASE must be positive");
   end
   if ((longint'(TMR_BASE) << MAX_SHIFT) >= (longint'(1) << TMR_W)) begin : g_bad_width
      $error("pllg_lock_timer: TMR_W too narrow for the largest timeout");
   end

   logic [TMR_W-1:0] cnt;
   logic [TMR_W-1:0] load_val;

   always_comb begin
      if (code == '0) load_val = '0;
      else            load_val = TMR_W'(TMR_BASE) << (code - LT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (clear)               cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (tick && cnt != '0)   cnt <= cnt - TMR_W'(1);
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/pllg_gate_fsm.sv
module pllg_gate_fsm
   import pllg_pkg::*;
#(
   parameter int LT_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_core,
   input  logic            osc_ready,
   input  logic            lock_raw,
   input  logic            wake_fast,
   input  logic [LT_W-1:0] lock_code,
   input  logic            lock_bypass,
   input  logic            tmr_zero,
   output logic            tmr_clear,
   output logic            tmr_load,
   output logic            gate_en,
   output logic            clk_ready,
   output logic            lock_seen
);

   pllg_state_t state_q;
   logic        release_ok;

   assign tmr_clear  = !en_core;
   assign tmr_load   = en_core && (state_q == ST_START) && osc_ready;
   assign release_ok = wake_fast || ((lock_code == '0) ? lock_raw : tmr_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OFF;
         gate_en   <= 1'b0;
         clk_ready <= 1'b0;
         lock_seen <= 1'b0;
      end else if (!en_core) begin
         state_q   <= ST_OFF;
         gate_en   <= 1'b0;
         clk_ready <= 1'b0;
         lock_seen <= 1'b0;
      end else begin
         unique case (state_q)
            ST_OFF:   state_q <= ST_START;
            ST_START: if (osc_ready) state_q <= ST_ACQ;
            ST_ACQ: begin
               if (release_ok) begin
                  state_q   <= ST_RUN;
                  gate_en   <= 1'b1;
                  clk_ready <= 1'b1;
                  lock_seen <= !wake_fast || lock_raw;
               end
            end
            ST_RUN: begin
               lock_seen <= lock_seen || lock_raw;
               gate_en   <= lock_bypass || lock_raw || !lock_seen;
            end
            default: state_q <= ST_OFF;
         endcase
      end
   end

endmodule

// File: rtl/pllg_ctrl.sv
module pllg_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int LT_W        = 3,
   parameter int TMR_W       = 8,
   parameter int TMR_BASE    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic            osc_ready_i,
   input  logic            lock_raw_i,
   input  logic [LT_W-1:0] lock_time_i,
   input  logic            wake_fast_i,
   input  logic            lock_bypass_i,
   input  logic            slow_tick_i,
   output logic            gate_en_o,
   output logic            clk_ready_o,
   output logic            sync_busy_o
);

   if (LT_W < 1) begin : g_bad_lt
      $error("pllg_ctrl: LT_W must be at least 1");
   end

   logic en_q;
   logic busy_q;
   logic en_core;
   logic ack_src;
   logic ack_s;
   logic en_change;
   logic tmr_clear;
   logic tmr_load;
   logic tmr_zero;
   logic lock_seen;

   assign en_change = (enable_i != en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         en_q <= enable_i;
         if (en_change)           busy_q <= 1'b1;
         else if (ack_s == en_q)  busy_q <= 1'b0;
      end
   end

   pllg_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (en_q),
      .q     (en_core)
   );

   // acknowledge stays high on disable until the gate has closed
   assign ack_src = en_core || gate_en_o;

   pllg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_src),
      .q     (ack_s)
   );

   pllg_lock_timer #(
      .LT_W     (LT_W),
      .TMR_W    (TMR_W),
      .TMR_BASE (TMR_BASE)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clear),
      .load  (tmr_load),
      .code  (lock_time_i),
      .tick  (slow_tick_i),
      .zero  (tmr_zero)
   );

   pllg_gate_fsm #(.LT_W(LT_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_core     (en_core),
      .osc_ready   (osc_ready_i),
      .lock_raw    (lock_raw_i),
      .wake_fast   (wake_fast_i),
      .lock_code   (lock_time_i),
      .lock_bypass (lock_bypass_i),
      .tmr_zero    (tmr_zero),
      .tmr_clear   (tmr_clear),
      .tmr_load    (tmr_load),
      .gate_en     (gate_en_o),
      .clk_ready   (clk_ready_o),
      .lock_seen   (lock_seen)
   );

   assign sync_busy_o = busy_q;

endmodule

// File: rtl/pllg_ctrl_chk.sv
module pllg_ctrl_chk #(
   parameter int LT_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enable_i,
   input logic            lock_raw_i,
   input logic [LT_W-1:0] lock_time_i,
   input logic            wake_fast_i,
   input logic            lock_bypass_i,
   input logic            gate_en_o,
   input logic            clk_ready_o,
   input logic            sync_busy_o,
   input logic            en_q,
   input logic            en_core,
   input logic            lock_seen,
   input logic            tmr_zero
);

   // R2
   busy_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i != en_q) |=> sync_busy_o);

   // R4
   lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_ready_o) && !$past(wake_fast_i) && ($past(lock_time_i) == '0))
         |-> $past(lock_raw_i));

   // R5
   timer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_ready_o) && !$past(wake_fast_i) && ($past(lock_time_i) != '0))
         |-> $past(tmr_zero));

   // R7
   lock_loss_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready_o && lock_seen && !lock_bypass_i && !lock_raw_i && en_core)
         |=> !gate_en_o);

   // R9
   bypass_holds_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready_o && lock_bypass_i && en_core) |=> gate_en_o);

   // R10
   gate_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en_o |-> clk_ready_o);

   // R11
   gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_core |=> (!gate_en_o && !clk_ready_o));

endmodule

bind pllg_ctrl pllg_ctrl_chk #(.LT_W(LT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable_i      (enable_i),
   .lock_raw_i    (lock_raw_i),
   .lock_time_i   (lock_time_i),
   .wake_fast_i   (wake_fast_i),
   .lock_bypass_i (lock_bypass_i),
   .gate_en_o     (gate_en_o),
   .clk_ready_o   (clk_ready_o),
   .sync_busy_o   (sync_busy_o),
   .en_q          (en_q),
   .en_core       (en_core),
   .lock_seen     (lock_seen),
   .tmr_zero      (tmr_zero)
);

// File: tb/pllg_ctrl_bench.sv
`timescale 1ns/1ps
module pllg_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable_i = 1'b0;
   logic       osc_ready_i = 1'b1;
   logic       lock_raw_i = 1'b0;
   logic [2:0] lock_time_i = 3'd0;
   logic       wake_fast_i = 1'b0;
   logic       lock_bypass_i = 1'b0;
   logic       slow_tick_i = 1'b0;
   logic       gate_en_o;
   logic       clk_ready_o;
   logic       sync_busy_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   pllg_ctrl u_pllg_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable_i      (enable_i),
      .osc_ready_i   (osc_ready_i),
      .lock_raw_i    (lock_raw_i),
      .lock_time_i   (lock_time_i),
      .wake_fast_i   (wake_fast_i),
      .lock_bypass_i (lock_bypass_i),
      .slow_tick_i   (slow_tick_i),
      .gate_en_o     (gate_en_o),
      .clk_ready_o   (clk_ready_o),
      .sync_busy_o   (sync_busy_o)
   );

   // {wake_fast, lock_time[2:0], lock_start, bypass, exp_gate, exp_ready, exp_gate_after_loss}
   localparam logic [8:0] VEC [6] = '{
      9'b0_000_1_0_1_1_0,   // lock mode, locked: released, then gated on loss
      9'b0_000_0_0_0_0_0,   // lock mode, no lock: held
      9'b1_000_0_0_1_1_0,   // wake-fast: released without lock, gated after lock seen
      9'b1_101_0_1_1_1_1,   // wake-fast with bypass: always running
      9'b0_011_1_0_0_0_0,   // timer mode, no ticks: held despite lock
      9'b0_000_1_1_1_1_1    // lock mode with bypass
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic tick_pulse();
      slow_tick_i = 1'b1;
      step(1);
      slow_tick_i = 1'b0;
   endtask

   task automatic go_off();
      enable_i = 1'b0;
      step(10);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 gate", gate_en_o, 1'b0);
      chk("R1 ready", clk_ready_o, 1'b0);
      chk("R1 busy", sync_busy_o, 1'b0);

      // table-driven mode walk
      for (int i = 0; i < 6; i++) begin
         go_off();
         wake_fast_i   = VEC[i][8];
         lock_time_i   = VEC[i][7:5];
         lock_raw_i    = VEC[i][4];
         lock_bypass_i = VEC[i][3];
         enable_i      = 1'b1;
         step(10);
         chk($sformatf("R4/R5/R6 gate vec%0d", i), gate_en_o, VEC[i][2]);
         chk($sformatf("R10 ready vec%0d", i), clk_ready_o, VEC[i][1]);
         lock_raw_i = 1'b1;
         step(2);
         lock_raw_i = 1'b0;
         step(3);
         chk($sformatf("R7/R8/R9 gate after loss vec%0d", i), gate_en_o, VEC[i][0]);
      end

      // R2 / R6 exact timing, wake-fast with oscillator ready
      go_off();
      wake_fast_i = 1'b1; lock_time_i = 3'd0; lock_bypass_i = 1'b0; lock_raw_i = 1'b0;
      enable_i = 1'b1;
      step(1);
      chk("R2 busy set", sync_busy_o, 1'b1);
      step(4);
      chk("R2 busy still set", sync_busy_o, 1'b1);
      chk("R6 gate not yet", gate_en_o, 1'b0);
      step(1);
      chk("R2 busy cleared", sync_busy_o, 1'b0);
      chk("R6 gate at cycle 6", gate_en_o, 1'b1);
      chk("R10 ready with release", clk_ready_o, 1'b1);
      // R8 lock never seen: loss has no effect
      step(5);
      chk("R8 gate held before lock seen", gate_en_o, 1'b1);

      // R11 / R2 disable timing
      enable_i = 1'b0;
      step(3);
      chk("R11 gate before close", gate_en_o, 1'b1);
      step(1);
      chk("R11 gate closed", gate_en_o, 1'b0);
      chk("R11 ready cleared", clk_ready_o, 1'b0);
      step(2);
      chk("R2 disable busy", sync_busy_o, 1'b1);
      step(1);
      chk("R2 disable busy cleared", sync_busy_o, 1'b0);

      // R3 oscillator startup gating
      step(5);
      osc_ready_i = 1'b0;
      enable_i = 1'b1;
      step(12);
      chk("R3 held without startup", gate_en_o, 1'b0);
      chk("R3 ready held", clk_ready_o, 1'b0);
      osc_ready_i = 1'b1;
      step(1);
      chk("R3 one cycle after startup", gate_en_o, 1'b0);
      step(1);
      chk("R3 released", gate_en_o, 1'b1);

      // R5 timer code 1 (2 ticks), lock present throughout
      go_off();
      wake_fast_i = 1'b0; lock_time_i = 3'd1; lock_raw_i = 1'b1;
      enable_i = 1'b1;
      step(10);
      chk("R5 held before ticks", gate_en_o, 1'b0);
      tick_pulse();
      step(3);
      chk("R5 held after one tick", gate_en_o, 1'b0);
      tick_pulse();
      chk("R5 not yet after last tick", gate_en_o, 1'b0);
      step(1);
      chk("R5 released after count zero", gate_en_o, 1'b1);
      chk("R10 ready on timer release", clk_ready_o, 1'b1);
      // R7 exact lock follow
      lock_raw_i = 1'b0;
      step(1);
      chk("R7 gate drops with lock", gate_en_o, 1'b0);
      chk("R10 ready holds", clk_ready_o, 1'b1);
      lock_raw_i = 1'b1;
      step(1);
      chk("R7 gate returns with lock", gate_en_o, 1'b1);

      // R5 code 2 (4 ticks), R11 timer restarted
      go_off();
      lock_time_i = 3'd2;
      enable_i = 1'b1;
      step(10);
      for (int k = 0; k < 3; k++) begin
         tick_pulse();
         step(1);
      end
      chk("R5 held after three of four ticks", gate_en_o, 1'b0);
      tick_pulse();
      step(1);
      chk("R5 released after fourth tick", gate_en_o, 1'b1);

      go_off();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule